// File: doc/BRIEF.md
# Four-Level IO Page Table Walker

This block turns a device DMA input address into a translation by walking a four-level, first-stage page table that sits in memory. A request carries the input address, a read/write flag and the 64-bit context word that names the table. The word's low 12 bits are cleared to give the root table base, and bits [3:2] of the word give the depth. The walker then fetches one 8-byte entry per level over a single-outstanding read port. It stops at a leaf, or at the first fault it meets.

Each level takes a 9-bit slice of the input address as the table index. Write permission is accumulated by AND across every entry visited. A failed read of the top-level entry is reported differently from a failed read further down. Only one walk is in flight at a time. The result is presented for exactly one cycle.

Top module: `io_pt_walker`

## Requirements
- R1: The start level is 4 plus `req_pe_word[3:2]`. Any value other than 4 ends the request with fault code 1 (bad context word), level 0, entry 0, both permissions false, and no memory read.
- R2: The root base is `req_pe_word` with bits [11:0] cleared. At level L, the index is `iova[12+9*(L-1) +: 9]` and the entry is read at address base + index*8.
- R3: A present, non-leaf entry gives the next base: the entry with bits [11:0] cleared and bits at or above `HAW` (default 48) cleared. The level then drops by one.
- R4: An entry is a leaf when the level is 1 or its bit 7 is set. A leaf with no fault returns the entry, its level and fault code 0.
- R5: An entry with bit 0 (present) clear ends the walk with fault code 3 (bad paging entry), both permissions false and the entry value returned.
- R6: Read permission is true once a present entry has been seen. Write permission is the AND of bit 1 (writable) of every entry visited.
- R7: A write request that meets an entry with bit 1 clear stops there with fault code 4. It returns that entry and level, with read true and write false.
- R8: A read error (`mem_rsp_err`) at level 4 gives fault code 2, and at any lower level gives fault code 3. In both cases the permissions reflect the entries already accepted, with entry 0 and the current level.
- R9: At most one read is outstanding. `mem_req_valid` holds with a stable address until `mem_req_ready`. No new read is issued until the response arrives.
- R10: `req_ready` is high only when idle. A request presented during a walk is ignored and has no effect on the result or on memory traffic.
- R11: `done` is a one-cycle pulse. A walk with k reads raises it 2k cycles after the accepting edge when the memory answers on the cycle after each read is accepted. A rejected request raises it on the cycle right after acceptance.
- R12: A synchronous reset returns the walker to idle: `req_ready` high, no read request, and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_iova | input | IOVA_W | Input address to translate |
| req_write | input | 1 | Request is a write |
| req_pe_word | input | 64 | Context word: table pointer and level field |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry value |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | One-cycle result pulse |
| res_entry | output | 64 | Leaf or faulting entry |
| res_level | output | 3 | Level where the walk stopped |
| res_rd | output | 1 | Read permitted |
| res_wr | output | 1 | Write permitted |
| res_fault | output | 3 | 0 none, 1 bad context word, 2 top read error, 3 bad paging entry, 4 write |

## Verification
Every accepted entry read costs two cycles: one for the handshake and one to consume the response. The memory model always answers on the cycle after it accepts a read. The bench therefore expects `done` exactly 2k cycles after the accepting edge for a k-read walk, and on the very next cycle for a rejected context word. It drives at the falling edge, counts falling edges from acceptance until `done`, and then compares both that count and the number of reads the model served against the vector. In the back-pressure test the read-ready toggles, so only the results and the read count are checked there; the result fields are sampled only on the falling edge where `done` is high.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
  localparam int PG_SHIFT  = 12;
  localparam int LVL_BITS  = 9;
  localparam int ENT_SHIFT = 3;
  localparam int TOP_LVL   = 4;
  localparam logic [63:0] PG_MASK = 64'((64'd1 << PG_SHIFT) - 64'd1);

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_BIGPAGE = 7;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_PASID = 3'd1,
    FLT_CTX   = 3'd2,
    FLT_PTE   = 3'd3,
    FLT_WRITE = 3'd4
  } pgw_fault_e;

  typedef enum logic [1:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_DONE
  } pgw_state_e;

  function automatic int unsigned lvl_shift(input logic [2:0] lvl);
    if (lvl == 3'd0) return PG_SHIFT;
    return PG_SHIFT + (int'(lvl) - 1) * LVL_BITS;
  endfunction

  function automatic logic [LVL_BITS-1:0] tbl_index(input logic [63:0] ia,
                                                   input logic [2:0] lvl);
    logic [63:0] sh;
    sh = ia >> lvl_shift(lvl);
    return sh[LVL_BITS-1:0];
  endfunction

  function automatic logic [63:0] haw_mask(input int haw);
    if (haw >= 64) return '1;
    return (64'd1 << haw) - 64'd1;
  endfunction
endpackage

// File: rtl/pgw_addr_gen.sv
`timescale 1ns/1ps
module pgw_addr_gen import pgw_pkg::*; #(
  parameter int IOVA_W = 48
) (
  input  logic [63:0]       base,
  input  logic [IOVA_W-1:0] iova,
  input  logic [2:0]        level,
  output logic [63:0]       ent_addr
);
  logic [LVL_BITS-1:0] idx;

  always_comb begin
    idx      = tbl_index(64'(iova), level);
    ent_addr = base + (64'(idx) << ENT_SHIFT);
  end
endmodule

// File: rtl/pgw_pte_eval.sv
`timescale 1ns/1ps
module pgw_pte_eval import pgw_pkg::*; #(
  parameter int HAW = 48
) (
  input  logic [63:0] pte,
  input  logic [2:0]  level,
  input  logic        want_write,
  input  logic        wr_acc,
  output logic        present,
  output logic        leaf,
  output logic        wr_fault,
  output logic        wr_next,
  output logic [63:0] next_base
);
  localparam logic [63:0] ADDR_KEEP = ~PG_MASK & haw_mask(HAW);

  always_comb begin
    present   = pte[BIT_PRESENT];
    leaf      = (level == 3'd1) || pte[BIT_BIGPAGE];
    wr_fault  = want_write && !pte[BIT_WRITE];
    wr_next   = wr_acc && pte[BIT_WRITE];
    next_base = pte & ADDR_KEEP;
  end
endmodule

// File: rtl/io_pt_walker.sv
`timescale 1ns/1ps
module io_pt_walker import pgw_pkg::*; #(
  parameter int IOVA_W = 48,
  parameter int HAW    = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IOVA_W-1:0] req_iova,
  input  logic              req_write,
  input  logic [63:0]       req_pe_word,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              done,
  output logic [63:0]       res_entry,
  output logic [2:0]        res_level,
  output logic              res_rd,
  output logic              res_wr,
  output logic [2:0]        res_fault
);
  localparam logic [2:0] START_LVL = 3'(TOP_LVL);

  pgw_state_e        st_q;
  logic [IOVA_W-1:0] ia_q;
  logic              wr_req_q;
  logic [63:0]       base_q;
  logic [2:0]        lvl_q;
  logic              rd_seen_q;
  logic              wr_acc_q;
  pgw_fault_e        fault_q;

  // named internal events
  logic [2:0] req_lvl;
  logic       pasid_ok;
  logic       evt_accept;
  logic       walk_busy;
  logic       rd_pending;
  logic       evt_rsp;

  logic        e_present, e_leaf, e_wr_fault, e_wr_next;
  logic [63:0] e_next_base;

  assign req_lvl    = START_LVL + {1'b0, req_pe_word[3:2]};
  assign pasid_ok   = (req_lvl == START_LVL);
  assign req_ready  = (st_q == S_IDLE);
  assign evt_accept = req_valid && req_ready;
  assign walk_busy  = (st_q != S_IDLE);
  assign rd_pending = (st_q == S_WAIT);
  assign evt_rsp    = rd_pending && mem_rsp_valid;

  assign mem_req_valid = (st_q == S_ISSUE);
  assign done          = (st_q == S_DONE);
  assign res_fault     = fault_q;

  pgw_addr_gen #(.IOVA_W(IOVA_W)) i_addr (
    .base     (base_q),
    .iova     (ia_q),
    .level    (lvl_q),
    .ent_addr (mem_req_addr)
  );

  pgw_pte_eval #(.HAW(HAW)) i_eval (
    .pte        (mem_rsp_data),
    .level      (lvl_q),
    .want_write (wr_req_q),
    .wr_acc     (wr_acc_q),
    .present    (e_present),
    .leaf       (e_leaf),
    .wr_fault   (e_wr_fault),
    .wr_next    (e_wr_next),
    .next_base  (e_next_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      ia_q      <= '0;
      wr_req_q  <= 1'b0;
      base_q    <= '0;
      lvl_q     <= '0;
      rd_seen_q <= 1'b0;
      wr_acc_q  <= 1'b0;
      fault_q   <= FLT_NONE;
      res_entry <= '0;
      res_level <= '0;
      res_rd    <= 1'b0;
      res_wr    <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (evt_accept) begin
            ia_q      <= req_iova;
            wr_req_q  <= req_write;
            base_q    <= req_pe_word & ~PG_MASK;
            lvl_q     <= req_lvl;
            rd_seen_q <= 1'b0;
            wr_acc_q  <= 1'b1;
            if (!pasid_ok) begin
              fault_q   <= FLT_PASID;
              res_entry <= '0;
              res_level <= '0;
              res_rd    <= 1'b0;
              res_wr    <= 1'b0;
              st_q      <= S_DONE;
            end else begin
              st_q <= S_ISSUE;
            end
          end
        end
        S_ISSUE: begin
          if (mem_req_ready) st_q <= S_WAIT;
        end
        S_WAIT: begin
          if (evt_rsp) begin
            res_level <= lvl_q;
            if (mem_rsp_err) begin
              fault_q   <= (lvl_q == START_LVL) ? FLT_CTX : FLT_PTE;
              res_entry <= '0;
              res_rd    <= rd_seen_q;
              res_wr    <= rd_seen_q && wr_acc_q;
              st_q      <= S_DONE;
            end else if (!e_present) begin
              fault_q   <= FLT_PTE;
              res_entry <= mem_rsp_data;
              res_rd    <= 1'b0;
              res_wr    <= 1'b0;
              st_q      <= S_DONE;
            end else if (e_wr_fault) begin
              fault_q   <= FLT_WRITE;
              res_entry <= mem_rsp_data;
              res_rd    <= 1'b1;
              res_wr    <= 1'b0;
              st_q      <= S_DONE;
            end else if (e_leaf) begin
              fault_q   <= FLT_NONE;
              res_entry <= mem_rsp_data;
              res_rd    <= 1'b1;
              res_wr    <= e_wr_next;
              st_q      <= S_DONE;
            end else begin
              base_q    <= e_next_base;
              lvl_q     <= lvl_q - 3'd1;
              rd_seen_q <= 1'b1;
              wr_acc_q  <= e_wr_next;
              st_q      <= S_ISSUE;
            end
          end
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgw_checker.sv
`timescale 1ns/1ps
module pgw_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_lvl_field,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        rd_pending,
  input logic        walk_busy,
  input logic        done,
  input logic [2:0]  res_fault,
  input logic [2:0]  res_level,
  input logic        res_entry_big,
  input logic        res_rd,
  input logic        res_wr
);
  p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_single_read_r9: assert property (@(posedge clk) disable iff (rst)
    rd_pending |-> !mem_req_valid);

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && walk_busy));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_reject_word_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_lvl_field != 2'd0) |=>
      (done && res_fault == 3'd1 && !res_rd && !res_wr && !mem_req_valid));

  p_leaf_shape_r4: assert property (@(posedge clk) disable iff (rst)
    (done && res_fault == 3'd0) |-> (res_rd && (res_level == 3'd1 || res_entry_big)));

  p_write_fault_r7: assert property (@(posedge clk) disable iff (rst)
    (done && res_fault == 3'd4) |-> (res_rd && !res_wr));

  p_wr_needs_rd_r6: assert property (@(posedge clk) disable iff (rst)
    (done && res_wr) |-> res_rd);

  p_reset_idle_r12: assert property (@(posedge clk)
    rst |=> (req_ready && !mem_req_valid && !done));
endmodule

bind io_pt_walker pgw_checker i_pgw_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_lvl_field (req_pe_word[3:2]),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rd_pending    (rd_pending),
  .walk_busy     (walk_busy),
  .done          (done),
  .res_fault     (res_fault),
  .res_level     (res_level),
  .res_entry_big (res_entry[7]),
  .res_rd        (res_rd),
  .res_wr        (res_wr)
);

// File: tb/test_io_pt_walker.sv
`timescale 1ns/1ps
module test_io_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_iova = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_pe_word = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        done;
  logic [63:0] res_entry;
  logic [2:0]  res_level;
  logic        res_rd, res_wr;
  logic [2:0]  res_fault;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  io_pt_walker i_io_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_iova(req_iova), .req_write(req_write), .req_pe_word(req_pe_word),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err), .done(done),
    .res_entry(res_entry), .res_level(res_level), .res_rd(res_rd),
    .res_wr(res_wr), .res_fault(res_fault)
  );

  // memory model: answers one cycle after accepting a read
  logic [63:0] mem [logic [63:0]];
  logic [63:0] err_addr = '0;
  logic        err_en = 1'b0;
  logic        slow = 1'b0;
  int          rd_cnt = 0;
  logic [63:0] alog [$];

  always @(posedge clk) begin
    if (rst) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
    end else begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
        mem_rsp_err   <= err_en && (mem_req_addr == err_addr);
        rd_cnt        <= rd_cnt + 1;
        alog.push_back(mem_req_addr);
      end
    end
    mem_req_ready <= slow ? ~mem_req_ready : 1'b1;
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ctx_word(input logic [1:0] lf);
    return 64'h1000 | (64'(lf) << 2) | 64'h3;
  endfunction

  // bench's own address rule: 9-bit slice per level, 8-byte entries
  function automatic logic [63:0] ent_at(input logic [63:0] base,
                                         input logic [47:0] ia, input int lvl);
    logic [63:0] slice;
    slice = (64'(ia) / (64'd1 << (12 + 9 * (lvl - 1)))) % 64'd512;
    return base + slice * 64'd8;
  endfunction

  task automatic run_walk(input logic [47:0] ia, input logic wr, input logic [63:0] pe,
                          output logic [63:0] e, output logic [2:0] l,
                          output logic r, output logic w, output logic [2:0] f,
                          output int lat, output int nr);
    logic acc;
    int   r0;
    @(negedge clk);
    req_valid = 1'b1; req_iova = ia; req_write = wr; req_pe_word = pe;
    acc = 1'b0; r0 = 0;
    while (!acc) begin
      acc = req_ready;
      r0  = rd_cnt;
      @(posedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    e = res_entry; l = res_level; r = res_rd; w = res_wr; f = res_fault;
    nr = rd_cnt - r0;
    @(negedge clk);
    chk("R11", "done drops after one cycle", 64'(done), 64'd0);
  endtask

  typedef struct packed {
    logic [47:0] ia;
    logic        wr;
    logic [1:0]  lf;
    logic [63:0] entry;
    logic [2:0]  lvl;
    logic        rd;
    logic        wrp;
    logic [2:0]  flt;
    logic [3:0]  nreads;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{48'h0080_8060_4123, 1'b0, 2'd0, 64'hABCD_E003, 3'd1, 1'b1, 1'b1, 3'd0, 4'd4}, // R2 R4 full walk read
    '{48'h0080_8060_4123, 1'b1, 2'd0, 64'hABCD_E003, 3'd1, 1'b1, 1'b1, 3'd0, 4'd4}, // R6 full walk write
    '{48'h0080_80A0_0456, 1'b0, 2'd0, 64'h4020_0083, 3'd2, 1'b1, 1'b1, 3'd0, 4'd3}, // R4 big page at level 2
    '{48'h0080_C000_0010, 1'b0, 2'd0, 64'h0000_7003, 3'd1, 1'b1, 1'b0, 3'd0, 4'd4}, // R6 read-only on path
    '{48'h0080_C000_0010, 1'b1, 2'd0, 64'h0000_5001, 3'd3, 1'b1, 1'b0, 3'd4, 4'd2}, // R7 write fault
    '{48'h0081_0000_0000, 1'b0, 2'd0, 64'h0000_0000, 3'd3, 1'b0, 1'b0, 3'd3, 4'd2}, // R5 absent at level 3
    '{48'h0380_0000_0000, 1'b1, 2'd0, 64'h0000_0000, 3'd4, 1'b0, 1'b0, 3'd3, 4'd1}, // R5 absent at root
    '{48'h0080_8060_4123, 1'b0, 2'd1, 64'h0000_0000, 3'd0, 1'b0, 1'b0, 3'd1, 4'd0}, // R1 level field 1
    '{48'h0080_8060_4123, 1'b1, 2'd3, 64'h0000_0000, 3'd0, 1'b0, 1'b0, 3'd1, 4'd0}, // R1 level field 3
    '{48'h0100_0000_0789, 1'b0, 2'd0, 64'h4000_0083, 3'd3, 1'b1, 1'b1, 3'd0, 4'd2}  // R3 high bits masked
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] e;
    logic [2:0]  l, f;
    logic        r, w;
    int          lat, nr, c0, extra;

    mem[64'h1008] = 64'h0000_0000_0000_2003;
    mem[64'h1010] = 64'hFFFF_0000_0000_8003;
    mem[64'h2010] = 64'h0000_0000_0000_3003;
    mem[64'h2018] = 64'h0000_0000_0000_5001;
    mem[64'h3018] = 64'h0000_0000_0000_4003;
    mem[64'h3028] = 64'h0000_0000_4020_0083;
    mem[64'h4020] = 64'h0000_0000_ABCD_E003;
    mem[64'h5000] = 64'h0000_0000_0000_6003;
    mem[64'h6000] = 64'h0000_0000_0000_7003;
    mem[64'h8000] = 64'h0000_0000_4000_0083;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "req_ready after reset", 64'(req_ready), 64'd1);
    chk("R12", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    chk("R12", "done after reset", 64'(done), 64'd0);

    for (int v = 0; v < NV; v++) begin
      run_walk(VECS[v].ia, VECS[v].wr, ctx_word(VECS[v].lf), e, l, r, w, f, lat, nr);
      if (v == 0) begin
        // R2 entry addresses of the four-level walk
        chk("R2", "read count", 64'(alog.size()), 64'd4);
        if (alog.size() == 4) begin
          chk("R2", "addr L4", alog[0], ent_at(64'h1000, VECS[0].ia, 4));
          chk("R2", "addr L3", alog[1], ent_at(64'h2000, VECS[0].ia, 3));
          chk("R2", "addr L2", alog[2], ent_at(64'h3000, VECS[0].ia, 2));
          chk("R2", "addr L1", alog[3], ent_at(64'h4000, VECS[0].ia, 1));
        end
      end
      $display("vector %0d", v);
      chk("vec", "entry",  e, VECS[v].entry);
      chk("vec", "level",  64'(l), 64'(VECS[v].lvl));
      chk("vec", "rd",     64'(r), 64'(VECS[v].rd));
      chk("vec", "wr",     64'(w), 64'(VECS[v].wrp));
      chk("vec", "fault",  64'(f), 64'(VECS[v].flt));
      chk("vec", "reads",  64'(nr), 64'(VECS[v].nreads));
      chk("R11", "latency", 64'(lat), 64'(2 * VECS[v].nreads));
    end

    // R8 read error on the root entry
    err_en = 1'b1; err_addr = 64'h1008;
    run_walk(48'h0080_8060_4123, 1'b0, ctx_word(2'd0), e, l, r, w, f, lat, nr);
    chk("R8", "top error fault", 64'(f), 64'd2);
    chk("R8", "top error rd", 64'(r), 64'd0);
    chk("R8", "top error wr", 64'(w), 64'd0);
    chk("R8", "top error level", 64'(l), 64'd4);

    // R8 read error at level 2
    err_addr = 64'h3018;
    run_walk(48'h0080_8060_4123, 1'b0, ctx_word(2'd0), e, l, r, w, f, lat, nr);
    chk("R8", "lower error fault", 64'(f), 64'd3);
    chk("R8", "lower error rd", 64'(r), 64'd1);
    chk("R8", "lower error wr", 64'(w), 64'd1);
    chk("R8", "lower error level", 64'(l), 64'd2);
    err_en = 1'b0;

    // R9 back-pressure on the read port
    slow = 1'b1;
    run_walk(48'h0080_8060_4123, 1'b1, ctx_word(2'd0), e, l, r, w, f, lat, nr);
    chk("R9", "entry under stall", e, 64'hABCD_E003);
    chk("R9", "reads under stall", 64'(nr), 64'd4);
    slow = 1'b0;
    repeat (2) @(negedge clk);

    // R10 request during a walk is ignored
    @(negedge clk);
    req_valid = 1'b1; req_iova = 48'h0080_8060_4123; req_write = 1'b0;
    req_pe_word = ctx_word(2'd0);
    c0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_iova = 48'h0380_0000_0000; req_write = 1'b1;
    chk("R10", "ready low while busy", 64'(req_ready), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    extra = 0;
    while (!done && extra < 2000) begin @(negedge clk); extra++; end
    chk("R10", "first walk entry", res_entry, 64'hABCD_E003);
    chk("R10", "first walk fault", 64'(res_fault), 64'd0);
    extra = 0;
    repeat (12) begin @(negedge clk); if (done) extra++; end
    chk("R10", "no second result", 64'(extra), 64'd0);
    chk("R10", "reads of one walk", 64'(rd_cnt - c0), 64'd4);

    // R12 reset in the middle of a walk
    @(negedge clk);
    req_valid = 1'b1; req_iova = 48'h0080_8060_4123; req_pe_word = ctx_word(2'd0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R12", "idle after mid reset", 64'(req_ready), 64'd1);
    chk("R12", "no read after mid reset", 64'(mem_req_valid), 64'd0);
    c0 = rd_cnt; extra = 0;
    repeat (10) begin @(negedge clk); if (done) extra++; end
    chk("R12", "no result after reset", 64'(extra), 64'd0);
    chk("R12", "no reads after reset", 64'(rd_cnt - c0), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule